// File: doc/BRIEF.md
# Relocating Program Image Loader

This block takes a program image delivered as a stream of 32-bit words over a valid/ready handshake and places it in a word-addressed memory. The image opens with a fixed header. A relocation table comes after the header, and the text and data words come last. The loader checks the header, keeps the relocation offsets in a small internal table and copies the segment words to consecutive addresses starting at the current load base. It then makes a read-modify-write pass over the memory that adds the load base to every word the table names.

When the pass ends, the loader presents the relocated entry point, the end of the text segment and the end of the whole image (text, data and uninitialised data). The end of the text segment and the end of the image are the values a processor would copy into its two pointer registers. The loader then moves its load base past the image, so that the next image loads directly above it. A bad signature, a relocation count that does not fit the table, and a stream that ends early each stop the load with a distinct error code. After an error the base does not move.

The memory port has a one-cycle read latency. A load begins with a one-cycle `start` pulse while the loader is idle, finished or in error.

Top module: `image_loader`

## Requirements
- R1: After reset `done`, `err` and `in_ready` are 0, `err_code` is 0 and `load_base` equals the parameter `RESET_BASE`.
- R2: The first stream word must equal 32'h58454E4E. Any other value ends the load with `err`=1 and `err_code`=1, and no memory write takes place.
- R3: Header words 3 to 7 are taken in this fixed order: entry offset, text size, data size, uninitialised size, relocation count. The loader discards the second word. On success `entry_addr` = base + entry offset.
- R4: On success `text_end` = base + text size and `image_end` = base + text + data + uninitialised size.
- R5: The text+data words that follow the relocation table are written to addresses base, base+1, and so on, in stream order.
- R6: For each relocation offset, the word at base + offset is read back, increased by base and written back. An offset listed twice gets the base added twice.
- R7: Each relocation read is followed, two cycles after `mem_re`, by a write to the same address. No write occurs in the cycle right after a read.
- R8: A relocation count larger than the parameter `RELOC_DEPTH` ends the load with `err_code`=3 before any memory write.
- R9: A word that carries `in_last` before the final word the header promises ends the load with `err_code`=2. That word is not written, and `in_ready` stays 0 afterwards.
- R10: A successful load sets `load_base` to the previous base plus the three segment sizes. An error leaves `load_base` unchanged.
- R11: An image with a relocation count of 0 and text+data size 0 completes after its seventh word without accessing memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (idle, finished or error state only) |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Marks the last word the sender has |
| in_ready | output | 1 | Loader accepts a stream word |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable, data returned one cycle later |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | Load completed, results valid |
| err | output | 1 | Load aborted |
| err_code | output | 2 | 1 signature, 2 truncated, 3 table overflow |
| entry_addr | output | 32 | Relocated entry point |
| text_end | output | 32 | Base plus text size |
| image_end | output | 32 | Base plus all segment sizes |
| load_base | output | AW | Current load base |

## Verification
A wrong header field index or a wrong copy pointer shows up as a wrong word at a known memory address or as wrong values on `entry_addr` and `text_end` once `done` rises. A relocation engine that reads too early, or that adds the base before the previous write has landed, leaves a wrong sum in the target word. The duplicate-offset case exposes it within two relocation entries. A phase counter that miscounts by one shows at the ports either as a spurious truncation error on the final word or as `done` arriving one word early.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam logic [31:0] IMAGE_MAGIC = 32'h58454E4E;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_MAGIC = 2'd1;
  localparam logic [1:0] ERR_SHORT = 2'd2;
  localparam logic [1:0] ERR_TABLE = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MAGIC, ST_SKIP, ST_HDR, ST_TABLE, ST_COPY,
    ST_RL_TBL, ST_RL_ADDR, ST_RL_WAIT, ST_RL_MOD,
    ST_FINISH, ST_DONE, ST_ERR
  } ld_state_e;
endpackage

// File: rtl/reloc_buf.sv
module reloc_buf #(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ld_counter.sv
module ld_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/image_loader.sv
module image_loader
  import loader_pkg::*;
#(
  parameter int              AW          = 16,
  parameter int              RELOC_DEPTH = 16,
  parameter logic [AW-1:0]   RESET_BASE  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic [31:0]   entry_addr,
  output logic [31:0]   text_end,
  output logic [31:0]   image_end,
  output logic [AW-1:0] load_base
);
  localparam int IW = (RELOC_DEPTH > 1) ? $clog2(RELOC_DEPTH) : 1;

  ld_state_e     state;
  logic [2:0]    hidx;
  logic [31:0]   ent_r, txt_r, dat_r, bss_r, nrel_r;
  logic [AW-1:0] base_q, ptr;
  logic [IW-1:0] tidx, ridx;
  logic [31:0]   buf_rdata;

  logic        acc, cnt_load, cnt_dec, cnt_last;
  logic [31:0] cnt_val, copy_len, base32;

  assign base32   = {{(32-AW){1'b0}}, base_q};
  assign copy_len = txt_r + dat_r;
  assign in_ready = (state == ST_MAGIC) || (state == ST_SKIP) || (state == ST_HDR) ||
                    (state == ST_TABLE) || (state == ST_COPY);
  assign acc       = in_valid && in_ready;
  assign done      = (state == ST_DONE);
  assign err       = (state == ST_ERR);
  assign load_base = base_q;

  // Phase counter loads: table length, copy length, relocation pass length.
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    if (acc && state == ST_HDR && hidx == 3'd4) begin
      cnt_load = 1'b1;
      cnt_val  = (in_data != 0) ? in_data : copy_len;
    end else if (acc && state == ST_TABLE) begin
      cnt_load = cnt_last;
      cnt_val  = (copy_len != 0) ? copy_len : nrel_r;
      cnt_dec  = 1'b1;
    end else if (acc && state == ST_COPY) begin
      cnt_load = cnt_last;
      cnt_val  = nrel_r;
      cnt_dec  = 1'b1;
    end else if (state == ST_RL_MOD) begin
      cnt_dec  = 1'b1;
    end
  end

  ld_counter #(.W(32)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  reloc_buf #(.DEPTH(RELOC_DEPTH), .IW(IW)) u_tbl (
    .clk(clk), .we(acc && state == ST_TABLE), .waddr(tidx), .wdata(in_data),
    .raddr(ridx), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hidx       <= '0;
      {ent_r, txt_r, dat_r, bss_r, nrel_r} <= '0;
      base_q     <= RESET_BASE;
      ptr        <= RESET_BASE;
      tidx       <= '0;
      ridx       <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      err_code   <= ERR_NONE;
      entry_addr <= '0;
      text_end   <= '0;
      image_end  <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE, ST_ERR: if (start) begin
          state    <= ST_MAGIC;
          err_code <= ERR_NONE;
          hidx     <= '0;
          tidx     <= '0;
          ridx     <= '0;
          ptr      <= base_q;
        end
        ST_MAGIC: if (acc) begin
          if (in_data != IMAGE_MAGIC) begin state <= ST_ERR; err_code <= ERR_MAGIC; end
          else if (in_last)           begin state <= ST_ERR; err_code <= ERR_SHORT; end
          else state <= ST_SKIP;
        end
        ST_SKIP: if (acc) begin
          if (in_last) begin state <= ST_ERR; err_code <= ERR_SHORT; end
          else state <= ST_HDR;
        end
        ST_HDR: if (acc) begin
          hidx <= hidx + 3'd1;
          case (hidx)
            3'd0: ent_r <= in_data;
            3'd1: txt_r <= in_data;
            3'd2: dat_r <= in_data;
            3'd3: bss_r <= in_data;
            default: nrel_r <= in_data;
          endcase
          if (hidx == 3'd4) begin
            if (in_data > 32'(RELOC_DEPTH)) begin state <= ST_ERR; err_code <= ERR_TABLE; end
            else if (in_data != 0 || copy_len != 0) begin
              if (in_last) begin state <= ST_ERR; err_code <= ERR_SHORT; end
              else state <= (in_data != 0) ? ST_TABLE : ST_COPY;
            end else state <= ST_FINISH;
          end else if (in_last) begin
            state <= ST_ERR; err_code <= ERR_SHORT;
          end
        end
        ST_TABLE: if (acc) begin
          tidx <= tidx + 1'b1;
          if (cnt_last) begin
            if (copy_len == 0)  state <= ST_RL_TBL;
            else if (in_last)   begin state <= ST_ERR; err_code <= ERR_SHORT; end
            else                state <= ST_COPY;
          end else if (in_last) begin
            state <= ST_ERR; err_code <= ERR_SHORT;
          end
        end
        ST_COPY: if (acc) begin
          if (in_last && !cnt_last) begin
            state <= ST_ERR; err_code <= ERR_SHORT;
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= ptr;
            mem_wdata <= in_data;
            ptr       <= ptr + 1'b1;
            if (cnt_last) state <= (nrel_r != 0) ? ST_RL_TBL : ST_FINISH;
          end
        end
        ST_RL_TBL:  state <= ST_RL_ADDR;
        ST_RL_ADDR: begin
          mem_re   <= 1'b1;
          mem_addr <= base_q + buf_rdata[AW-1:0];
          state    <= ST_RL_WAIT;
        end
        ST_RL_WAIT: state <= ST_RL_MOD;
        ST_RL_MOD: begin
          mem_we    <= 1'b1;
          mem_wdata <= mem_rdata + base32;
          ridx      <= ridx + 1'b1;
          state     <= cnt_last ? ST_FINISH : ST_RL_TBL;
        end
        ST_FINISH: begin
          entry_addr <= base32 + ent_r;
          text_end   <= base32 + txt_r;
          image_end  <= base32 + copy_len + bss_r;
          base_q     <= base_q + AW'(copy_len + bss_r);
          state      <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          in_ready,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          err,
  input logic [1:0]    err_code,
  input logic [AW-1:0] load_base
);
  logic wrote;

  always_ff @(posedge clk) begin
    if (rst || start) wrote <= 1'b0;
    else if (mem_we)  wrote <= 1'b1;
  end

  assert_no_write_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_we);

  assert_rmw_same_addr_R7: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> ##1 (mem_we && mem_addr == $past(mem_addr, 2)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(err) && err_code == 2'd3) |-> !wrote);

  assert_magic_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(err) && err_code == 2'd1) |-> !wrote);

  assert_stop_after_error_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> !in_ready);

  assert_base_moves_on_done_R10: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(load_base));
endmodule

bind image_loader loader_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .done(done), .err(err),
  .err_code(err_code), .load_base(load_base)
);

// File: tb/image_loader_tb.sv
module image_loader_tb;
  localparam int AW    = 10;
  localparam int DEPTH = 4;
  localparam logic [AW-1:0] BASE0 = 10'h100;
  localparam logic [31:0] MAGIC = 32'h58454E4E;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, mem_we, mem_re, done, err;
  logic [AW-1:0] mem_addr, load_base;
  logic [31:0] mem_wdata, mem_rdata, entry_addr, text_end, image_end;
  logic [1:0] err_code;

  logic [31:0] mem [1024];
  logic [31:0] img [64];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  image_loader #(.AW(AW), .RELOC_DEPTH(DEPTH), .RESET_BASE(BASE0)) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .err_code(err_code), .entry_addr(entry_addr),
    .text_end(text_end), .image_end(image_end), .load_base(load_base)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] init_val(int a);
    return 32'hA5A5_0000 + 32'(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic kick;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Send words 0..last_at, with in_last on word last_at; optional idle gaps.
  task automatic send(input int last_at, input bit gaps);
    for (int i = 0; i <= last_at; i++) begin
      bit accepted = 1'b0;
      @(negedge clk);
      if (err) break;
      if (gaps && (i % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = img[i];
      in_last  = (i == last_at);
      while (!accepted) begin
        #1;
        if (in_ready) begin
          @(posedge clk);
          accepted = 1'b1;
        end else begin
          if (err) break;
          @(negedge clk);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (!done && !err && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 2000) chk({req, " end"}, 32'hDEAD, 32'h0);
  endtask

  task automatic header(input logic [31:0] ent, nb, ns, nbss, nrel);
    img[0] = MAGIC; img[1] = 32'h1234_5678;
    img[2] = ent; img[3] = nb; img[4] = ns; img[5] = nbss; img[6] = nrel;
  endtask

  task automatic t_reset;
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 ready", 32'(in_ready), 0);
    chk("R1 code", 32'(err_code), 0);
    chk("R1 base", 32'(load_base), 32'(BASE0));
  endtask

  task automatic t_basic;
    header(2, 4, 2, 3, 2);
    img[7] = 1; img[8] = 4;
    for (int k = 0; k < 6; k++) img[9+k] = 32'h10 * (k + 1);
    kick();
    send(14, 1'b0);
    wait_end("R5");
    chk("R3 done", 32'(done), 1);
    chk("R3 entry", entry_addr, 32'h102);
    chk("R4 text_end", text_end, 32'h104);
    chk("R4 image_end", image_end, 32'h109);
    chk("R5 word0", mem[10'h100], 32'h10);
    chk("R5 word2", mem[10'h102], 32'h30);
    chk("R5 word5", mem[10'h105], 32'h60);
    chk("R6 reloc1", mem[10'h101], 32'h120);
    chk("R6 reloc4", mem[10'h104], 32'h150);
    chk("R10 base", 32'(load_base), 32'h109);
  endtask

  task automatic t_dup_gaps;
    header(0, 1, 0, 0, 2);
    img[7] = 0; img[8] = 0; img[9] = 7;
    kick();
    send(9, 1'b1);
    wait_end("R6");
    chk("R6 dup sum", mem[10'h109], 32'h7 + 2 * 32'h109);
    chk("R3 entry", entry_addr, 32'h109);
    chk("R4 image_end", image_end, 32'h10A);
    chk("R10 base", 32'(load_base), 32'h10A);
  endtask

  task automatic t_magic;
    header(0, 1, 0, 0, 0);
    img[0] = 32'h1234_5678; img[7] = 9;
    kick();
    send(7, 1'b0);
    wait_end("R2");
    chk("R2 err", 32'(err), 1);
    chk("R2 code", 32'(err_code), 1);
    chk("R2 mem", mem[10'h10A], init_val(10'h10A));
    chk("R10 base", 32'(load_base), 32'h10A);
  endtask

  task automatic t_overflow;
    header(0, 1, 0, 0, DEPTH + 1);
    for (int k = 0; k < 6; k++) img[7+k] = 0;
    kick();
    send(12, 1'b0);
    wait_end("R8");
    chk("R8 code", 32'(err_code), 3);
    chk("R8 mem", mem[10'h10A], init_val(10'h10A));
    chk("R10 base", 32'(load_base), 32'h10A);
  endtask

  task automatic t_trunc;
    header(0, 3, 0, 0, 0);
    img[7] = 32'h55; img[8] = 32'h66; img[9] = 32'h77;
    kick();
    send(8, 1'b0);
    wait_end("R9");
    chk("R9 code", 32'(err_code), 2);
    chk("R9 ready", 32'(in_ready), 0);
    chk("R9 first word", mem[10'h10A], 32'h55);
    chk("R9 cut word", mem[10'h10B], init_val(10'h10B));
    chk("R10 base", 32'(load_base), 32'h10A);
  endtask

  task automatic t_empty;
    header(5, 0, 0, 0, 0);
    kick();
    send(6, 1'b0);
    wait_end("R11");
    chk("R11 done", 32'(done), 1);
    chk("R11 entry", entry_addr, 32'h10F);
    chk("R11 text_end", text_end, 32'h10A);
    chk("R11 base", 32'(load_base), 32'h10A);
    chk("R11 mem", mem[10'h10C], init_val(10'h10C));
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = init_val(a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dup_gaps();
    t_magic();
    t_overflow();
    t_trunc();
    t_empty();
    summary();
  end
endmodule